// File: doc/BRIEF.md
# Instruction Trace Down-Counter

This block lets a debug host run a processor core for an exact number of instructions at full speed and then pull it back into the halted debug state. While the core sits in debug mode, the host writes a start count and arms trace mode. The host then releases the core. Every retired-instruction pulse takes one from the count. Instructions retired inside interrupt handlers count the same way as any other.

When a retire pulse brings the count to zero, the block raises a one-cycle debug-entry request. It also sets a sticky trace-hit status flag and flips an attention line, which tells the host that service is wanted. The count is cleared at reset and every time the core enters debug mode, whatever caused the entry. The count does not move while the core is in debug mode or while trace is disarmed.

Top module: `insn_trace_counter`

## Requirements
- R1: While reset is held and after it is released, `count` is 0 and `trace_hit`, `brk_req`, `attn` and `trace_armed` are all 0.
- R2: A cycle with `load_we` high writes `load_data` into `count`, and the new value is visible in the following cycle. The load takes priority over a decrement and over the clear on debug entry in the same cycle.
- R3: A cycle with `retire` high takes exactly one from `count` only when `trace_armed` is 1, `in_debug` is 0 and `count` is nonzero. At all other times `count` holds its value.
- R4: When a retire pulse moves `count` from 1 to 0, `brk_req` is 1 for exactly the following cycle.
- R5: `trace_hit` becomes 1 in the same cycle that `brk_req` rises. It stays 1 until a `cfg_we` write with `cfg_hit_clr` = 1. If that clearing write falls in the same cycle as a new zero-reach, `trace_hit` stays 1.
- R6: `attn` inverts once for each zero-reach, in the same cycle that `brk_req` rises. At no other time does it change.
- R7: In the cycle after `in_debug` is first seen high following a low, `count` reads 0 unless a load occurs in that cycle. `trace_armed` is not affected by this clear.
- R8: A count of 0 never produces a request. Loading 0 while trace is armed and then retiring instructions leaves `count` at 0, `brk_req` at 0 and `attn` unchanged, with no wrap.
- R9: A `cfg_we` write copies `cfg_arm` into `trace_armed`, and the new value is visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_debug | input | 1 | High while the core is halted in debug mode |
| retire | input | 1 | One pulse per retired instruction |
| load_we | input | 1 | Count write strobe |
| load_data | input | CNT_W | Count start value |
| cfg_we | input | 1 | Control write strobe |
| cfg_arm | input | 1 | Trace-mode select written on `cfg_we` |
| cfg_hit_clr | input | 1 | Clears `trace_hit` when written as 1 on `cfg_we` |
| count | output | CNT_W | Present counter value |
| trace_armed | output | 1 | Trace-mode select bit |
| trace_hit | output | 1 | Sticky trace-occurred status |
| brk_req | output | 1 | One-cycle debug-entry request |
| attn | output | 1 | Attention line, inverted on each zero-reach |

## Verification
Two events can fall in the same cycle. One is the retire pulse that drops the count from one to zero, which sets `trace_hit`. The other is a host write that clears `trace_hit`. The bench provokes this by issuing the clearing `cfg_we` on the exact cycle of the final retire, and it expects `trace_hit` to remain 1 alongside the request. A second collision pairs a count load with a retire pulse, and the bench expects the loaded value to win.

// File: rtl/trc_pkg.sv
package trc_pkg;

  // Number of flops in the reset release synchronizer.
  localparam int unsigned RST_SYNC_STAGES = 2;

  // Outputs raised by a zero-reach event.
  typedef struct packed {
    logic hit;   // sticky trace-occurred flag
    logic attn;  // attention toggle line
    logic req;   // debug-entry request pulse
  } trc_status_t;

endpackage

// File: rtl/trc_rst_sync.sv
module trc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/trc_entry_det.sv
module trc_entry_det (
  input  logic clk,
  input  logic rst_n,
  input  logic in_debug,
  output logic entry
);

  logic dbg_q;
  logic dbg_d;

  always_comb begin
    dbg_d = in_debug;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dbg_q <= 1'b0;
    else        dbg_q <= dbg_d;
  end

  assign entry = in_debug & ~dbg_q;

endmodule

// File: rtl/trc_count.sv
module trc_count #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_we,
  input  logic [W-1:0] load_data,
  input  logic         clr,
  input  logic         step_en,
  output logic [W-1:0] cnt,
  output logic         hit
);

  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;
  logic         dec;

  // A decrement only happens with a nonzero count and no load or clear.
  assign dec = step_en & (cnt_q != ZERO) & ~load_we & ~clr;
  assign hit = dec & (cnt_q == ONE);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_we) begin
      cnt_en = 1'b1;
      cnt_d  = load_data;
    end else if (clr) begin
      cnt_en = 1'b1;
      cnt_d  = ZERO;
    end else if (dec) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= ZERO;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/trc_status.sv
module trc_status
  import trc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hit,
  input  logic        hit_clr,
  output trc_status_t st
);

  trc_status_t st_q;
  trc_status_t st_d;

  always_comb begin
    st_d      = st_q;
    st_d.req  = hit;
    // A new zero-reach outranks a host clear in the same cycle.
    if (hit)          st_d.hit = 1'b1;
    else if (hit_clr) st_d.hit = 1'b0;
    if (hit)          st_d.attn = ~st_q.attn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign st = st_q;

endmodule

// File: rtl/insn_trace_counter.sv
module insn_trace_counter
  import trc_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_debug,
  input  logic             retire,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_data,
  input  logic             cfg_we,
  input  logic             cfg_arm,
  input  logic             cfg_hit_clr,
  output logic [CNT_W-1:0] count,
  output logic             trace_armed,
  output logic             trace_hit,
  output logic             brk_req,
  output logic             attn
);

  logic        rst_n_s;
  logic        entry;
  logic        step_en;
  logic        hit;
  logic        arm_q;
  logic        arm_d;
  logic        arm_en;
  trc_status_t st;

  trc_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  trc_entry_det u_entry (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .in_debug (in_debug),
    .entry    (entry)
  );

  always_comb begin
    arm_en = cfg_we;
    arm_d  = cfg_arm;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    arm_q <= 1'b0;
    else if (arm_en) arm_q <= arm_d;
  end

  assign step_en = arm_q & ~in_debug & retire;

  trc_count #(.W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .load_we   (load_we),
    .load_data (load_data),
    .clr       (entry),
    .step_en   (step_en),
    .cnt       (count),
    .hit       (hit)
  );

  trc_status u_st (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .hit     (hit),
    .hit_clr (cfg_we & cfg_hit_clr),
    .st      (st)
  );

  assign trace_armed = arm_q;
  assign trace_hit   = st.hit;
  assign brk_req     = st.req;
  assign attn        = st.attn;

endmodule

// File: rtl/insn_trace_counter_chk.sv
module insn_trace_counter_chk #(
  parameter int unsigned CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_we,
  input logic             cfg_we,
  input logic             cfg_hit_clr,
  input logic [CNT_W-1:0] count,
  input logic             trace_hit,
  input logic             brk_req,
  input logic             attn
);

  // R4: request lasts one cycle
  a_r4_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |=> !brk_req);

  // R4: request only accompanies an empty counter
  a_r4_req_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> (count == '0));

  // R5: status raised together with the request
  a_r5_hit_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> trace_hit);

  // R5: status is sticky without a clearing write
  a_r5_hit_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_hit && !(cfg_we && cfg_hit_clr)) |=> trace_hit);

  // R6: attention line flips on each request
  a_r6_attn_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (!brk_req ##1 brk_req) |-> (attn != $past(attn)));

  // R6: attention line stays put without a request
  a_r6_attn_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !brk_req ##1 !brk_req |-> $stable(attn));

  // R8: an empty counter never wraps
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !load_we) |=> (count == '0));

  // R3: at most one step down per cycle unless loaded
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_we && count != '0) |=>
      (count == $past(count) || count == $past(count) - 1'b1 || count == '0));

endmodule

bind insn_trace_counter insn_trace_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .load_we     (load_we),
  .cfg_we      (cfg_we),
  .cfg_hit_clr (cfg_hit_clr),
  .count       (count),
  .trace_hit   (trace_hit),
  .brk_req     (brk_req),
  .attn        (attn)
);

// File: tb/sim_insn_trace_counter.sv
`timescale 1ns/1ps
module sim_insn_trace_counter;

  localparam int unsigned W = 24;

  logic         clk;
  logic         rst_n;
  logic         in_debug;
  logic         retire;
  logic         load_we;
  logic [W-1:0] load_data;
  logic         cfg_we;
  logic         cfg_arm;
  logic         cfg_hit_clr;
  logic [W-1:0] count;
  logic         trace_armed;
  logic         trace_hit;
  logic         brk_req;
  logic         attn;

  int n_chk;
  int n_bad;
  logic exp_attn;

  insn_trace_counter #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_debug(in_debug), .retire(retire),
    .load_we(load_we), .load_data(load_data), .cfg_we(cfg_we),
    .cfg_arm(cfg_arm), .cfg_hit_clr(cfg_hit_clr), .count(count),
    .trace_armed(trace_armed), .trace_hit(trace_hit), .brk_req(brk_req),
    .attn(attn)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Inputs are driven just after a falling edge; the outputs seen at the
  // next falling edge reflect the rising edge in between.
  task automatic idle();
    retire = 0; load_we = 0; cfg_we = 0; cfg_arm = trace_armed; cfg_hit_clr = 0;
  endtask

  task automatic cyc();
    @(negedge clk);
    idle();
  endtask

  task automatic do_load(input logic [W-1:0] v);
    load_we = 1; load_data = v; cyc();
  endtask

  task automatic do_cfg(input logic arm, input logic clr);
    cfg_we = 1; cfg_arm = arm; cfg_hit_clr = clr; cyc();
  endtask

  task automatic t_reset();
    rst_n = 0; in_debug = 0; retire = 0; load_we = 0; load_data = '0;
    cfg_we = 0; cfg_arm = 0; cfg_hit_clr = 0;
    repeat (3) @(negedge clk);
    check("R1 count in reset", count, 0);
    check("R1 hit in reset", {23'd0, trace_hit}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 count", count, 0);
    check("R1 brk_req", {23'd0, brk_req}, 0);
    check("R1 attn", {23'd0, attn}, 0);
    check("R1 armed", {23'd0, trace_armed}, 0);
    exp_attn = 0;
  endtask

  // Enter debug, load, arm, release, then retire n instructions.
  task automatic t_run(input logic [W-1:0] n);
    in_debug = 1; cyc(); cyc();
    do_load(n);
    check("R2 load value", count, n);
    do_cfg(1, 0);
    check("R9 armed", {23'd0, trace_armed}, 1);
    in_debug = 0; cyc();
    for (int i = 0; i < int'(n) - 1; i++) begin
      retire = 1; cyc();
      cyc();  // gap cycle with no retire
      check("R3 step", count, n - W'(i) - 1);
      check("R4 no early req", {23'd0, brk_req}, 0);
    end
    retire = 1; cyc();
    exp_attn = ~exp_attn;
    check("R4 req at zero", {23'd0, brk_req}, 1);
    check("R3 reached zero", count, 0);
    check("R5 hit set", {23'd0, trace_hit}, 1);
    check("R6 attn flip", {23'd0, attn}, {23'd0, exp_attn});
    cyc();
    check("R4 req one cycle", {23'd0, brk_req}, 0);
    check("R5 hit sticky", {23'd0, trace_hit}, 1);
  endtask

  task automatic t_no_count();
    in_debug = 1; cyc(); do_load(7);
    retire = 1; cyc();
    check("R3 hold in debug", count, 7);
    do_cfg(0, 0);
    in_debug = 0; cyc();
    retire = 1; cyc();
    check("R3 hold unarmed", count, 7);
  endtask

  task automatic t_entry_clear();
    do_cfg(1, 0);
    retire = 1; cyc();
    check("R3 armed step", count, 6);
    in_debug = 1; cyc();
    check("R7 clear on entry", count, 0);
    check("R7 arm kept", {23'd0, trace_armed}, 1);
    in_debug = 0; cyc();
    in_debug = 1; load_we = 1; load_data = 24'h123456; cyc();
    check("R2 load beats entry clear", count, 24'h123456);
  endtask

  task automatic t_zero_load();
    do_load(0);
    in_debug = 0; cyc();
    for (int i = 0; i < 3; i++) begin
      retire = 1; cyc();
    end
    cyc();
    check("R8 no wrap", count, 0);
    check("R8 no req", {23'd0, brk_req}, 0);
    check("R8 attn unchanged", {23'd0, attn}, {23'd0, exp_attn});
  endtask

  task automatic t_load_vs_retire();
    do_load(3);
    retire = 1; load_we = 1; load_data = 9; cyc();
    check("R2 load beats decrement", count, 9);
  endtask

  task automatic t_clear_collision();
    do_load(1);
    retire = 1; cfg_we = 1; cfg_arm = 1; cfg_hit_clr = 1; cyc();
    exp_attn = ~exp_attn;
    check("R5 set beats clear", {23'd0, trace_hit}, 1);
    check("R4 collision req", {23'd0, brk_req}, 1);
    check("R6 collision attn", {23'd0, attn}, {23'd0, exp_attn});
    do_cfg(1, 1);
    check("R5 host clear", {23'd0, trace_hit}, 0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    t_reset();
    t_run(5);
    t_run(2);
    t_no_count();
    t_entry_clear();
    t_zero_load();
    t_load_vs_retire();
    t_clear_collision();
    repeat (2) cyc();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule